// File: doc/BRIEF.md
# Parallel Display Bus Sequencer

This block carries single-byte transfers between a host and an external display controller over an 8-bit parallel bus. The control lines are a command/data select line, an active-low write strobe, an active-low read strobe and an active-low chip select. A transfer can be requested through a CPU-side request line or through a DMA request line. Either request takes the direction, the select-line value and the write byte that sit on the shared request fields.

Every transfer runs through three timed phases: setup, strobe and hold. The length of each phase comes from its own programmable count, so the bus can be matched to slow or fast display controllers. During setup the select line and chip select are driven but no strobe is active. During the strobe phase exactly one strobe is low. During hold the strobe is released while the select line, chip select and (on writes) the data driver stay in place.

Read data is captured into a one-byte buffer that raises a full flag. A level interrupt reports that the write side is free to accept a new byte. Requests that arrive while a transfer is running are ignored.

Top module: `lcd_par_ctrl`

## Requirements
- R1: After reset, lcd_cs_n, lcd_wr_n and lcd_rd_n are 1, lcd_d_oe is 0, busy is 0, irq_wr_empty is 1 and irq_rd_full is 0.
- R2: When idle, a 1 on cpu_req or dma_req is accepted at the clock edge. From the next cycle on, lcd_cs_n is 0, busy is 1 and lcd_a0 equals the req_a0 value that was sampled.
- R3: The setup phase lasts cfg_setup+1 cycles with lcd_cs_n at 0 and both strobes at 1. No strobe is low in the first cycle of chip select.
- R4: The strobe phase lasts cfg_wait+1 cycles. In it, lcd_wr_n is 0 when req_rd was 0 at acceptance, and lcd_rd_n is 0 when req_rd was 1. The two strobes are never low together.
- R5: The hold phase lasts cfg_hold+1 cycles with both strobes at 1. After it, lcd_cs_n returns to 1. lcd_a0 is stable for as long as lcd_cs_n is 0.
- R6: On a write, lcd_d_oe is 1 and lcd_d_o equals the accepted req_wdata for every cycle of chip select. lcd_d_oe is 0 once chip select ends. On a read, lcd_d_oe stays 0.
- R7: On a read, the value of lcd_d_i in the last strobe cycle is stored in rd_data, and irq_rd_full becomes 1 in the cycle in which lcd_rd_n returns to 1.
- R8: A 1 on rd_ack clears irq_rd_full at the next edge and leaves rd_data unchanged. A later read overwrites rd_data even if the buffer is still full.
- R9: busy is 1 for exactly the cycles in which lcd_cs_n is 0. A request that arrives while busy is 1 starts no transfer and changes no bus output.
- R10: irq_wr_empty is 1 exactly when busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_setup | input | CNT_W | Setup phase length minus one |
| cfg_wait | input | CNT_W | Strobe phase length minus one |
| cfg_hold | input | CNT_W | Hold phase length minus one |
| cpu_req | input | 1 | Transfer request from the host |
| dma_req | input | 1 | Transfer request from DMA |
| req_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| req_a0 | input | 1 | Command/data select value for the transfer |
| req_wdata | input | DATA_W | Byte to write |
| rd_ack | input | 1 | Host has taken the read buffer |
| rd_data | output | DATA_W | Read buffer contents |
| busy | output | 1 | Transfer in progress |
| irq_wr_empty | output | 1 | Write side free, level interrupt |
| irq_rd_full | output | 1 | Read buffer full, level interrupt |
| lcd_a0 | output | 1 | Command/data select line |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_d_o | output | DATA_W | Data bus output value |
| lcd_d_oe | output | 1 | Data bus output enable |
| lcd_d_i | input | DATA_W | Data bus input value |

## Verification
The assertions assume that the three phase counts stay constant while a transfer is running, because the phase counter reloads from them at each phase boundary. The stimulus honours this by changing the counts only while busy is 0, before it raises a request. The assertions also assume that lcd_d_i holds a known value during the read strobe. The bus model drives a fixed byte whenever lcd_rd_n is low, and the request fields are held steady in the accepting cycle.

// File: rtl/lcd_par_pkg.sv
package lcd_par_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } lcd_phase_e;

endpackage

// File: rtl/lcd_phase_cnt.sv
module lcd_phase_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // counter never wraps: a non-loading cycle only ever decreases it
   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (cnt_q <= $past(cnt_q)));  // R3

endmodule

// File: rtl/lcd_rd_buf.sv
module lcd_rd_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] din,
   input  logic              ack,
   output logic [DATA_W-1:0] dout,
   output logic              full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         full <= 1'b0;
      end else begin
         if (capture)
            dout <= din;
         if (capture)
            full <= 1'b1;
         else if (ack)
            full <= 1'b0;
      end
   end

   AST_RD_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (full && dout == $past(din)));  // R7

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !capture) |=> (!full && $stable(dout)));  // R8

endmodule

// File: rtl/lcd_par_ctrl.sv
module lcd_par_ctrl
   import lcd_par_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_setup,
   input  logic [CNT_W-1:0]  cfg_wait,
   input  logic [CNT_W-1:0]  cfg_hold,
   input  logic              cpu_req,
   input  logic              dma_req,
   input  logic              req_rd,
   input  logic              req_a0,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              rd_ack,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              irq_wr_empty,
   output logic              irq_rd_full,
   output logic              lcd_a0,
   output logic              lcd_cs_n,
   output logic              lcd_wr_n,
   output logic              lcd_rd_n,
   output logic [DATA_W-1:0] lcd_d_o,
   output logic              lcd_d_oe,
   input  logic [DATA_W-1:0] lcd_d_i
);

   localparam int MAX_PHASE = (1 << CNT_W);

   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data_w
         $error("lcd_par_ctrl: DATA_W must lie in 1..32");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("lcd_par_ctrl: CNT_W must lie in 1..16");
      end
      if (MAX_PHASE < 2) begin : g_bad_phase
         $error("lcd_par_ctrl: phase range too small");
      end
   endgenerate

   lcd_phase_e        phase_q;
   logic              is_rd_q;
   logic              a0_q;
   logic [DATA_W-1:0] wdata_q;
   logic              start;
   logic              ph_done;
   logic              cnt_load;
   logic [CNT_W-1:0]  cnt_val;
   logic              rd_capture;

   assign start = (cpu_req || dma_req) && (phase_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         is_rd_q <= 1'b0;
         a0_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: if (start) begin
               phase_q <= PH_SETUP;
               is_rd_q <= req_rd;
               a0_q    <= req_a0;
               wdata_q <= req_wdata;
            end
            PH_SETUP:  if (ph_done) phase_q <= PH_STROBE;
            PH_STROBE: if (ph_done) phase_q <= PH_HOLD;
            PH_HOLD:   if (ph_done) phase_q <= PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = cfg_setup;
      case (phase_q)
         PH_IDLE: begin
            cnt_load = start;
            cnt_val  = cfg_setup;
         end
         PH_SETUP: begin
            cnt_load = ph_done;
            cnt_val  = cfg_wait;
         end
         PH_STROBE: begin
            cnt_load = ph_done;
            cnt_val  = cfg_hold;
         end
         default: begin
            cnt_load = 1'b0;
            cnt_val  = cfg_setup;
         end
      endcase
   end

   lcd_phase_cnt #(.CNT_W(CNT_W)) i_phase_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .expired  (ph_done)
   );

   assign rd_capture = (phase_q == PH_STROBE) && ph_done && is_rd_q;

   lcd_rd_buf #(.DATA_W(DATA_W)) i_rd_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (rd_capture),
      .din     (lcd_d_i),
      .ack     (rd_ack),
      .dout    (rd_data),
      .full    (irq_rd_full)
   );

   assign busy         = (phase_q != PH_IDLE);
   assign irq_wr_empty = !busy;
   assign lcd_cs_n     = !busy;
   assign lcd_a0       = a0_q;
   assign lcd_wr_n     = !((phase_q == PH_STROBE) && !is_rd_q);
   assign lcd_rd_n     = !((phase_q == PH_STROBE) && is_rd_q);
   assign lcd_d_oe     = busy && !is_rd_q;
   assign lcd_d_o      = wdata_q;

   AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_cs_n) |-> (lcd_wr_n && lcd_rd_n));  // R3

   AST_A0_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_cs_n |=> (lcd_cs_n || $stable(lcd_a0)));  // R5

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (phase_q != PH_SETUP || $past(phase_q) == PH_SETUP));  // R9

   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_cs_n) |-> !lcd_d_oe);  // R6

   AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lcd_wr_n) || $fell(lcd_rd_n)) |-> $past(phase_q) == PH_SETUP);  // R4

endmodule

// File: tb/test_lcd_par_ctrl.sv
`timescale 1ns/1ps
module test_lcd_par_ctrl;

   localparam int DW = 8;
   localparam int CW = 4;

   typedef struct {
      bit       rd;
      bit       a0;
      bit [7:0] d;
      int       s, w, h;
   } xfer_t;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [CW-1:0] cfg_setup = 0, cfg_wait = 0, cfg_hold = 0;
   logic          cpu_req = 0, dma_req = 0, req_rd = 0, req_a0 = 0, rd_ack = 0;
   logic [DW-1:0] req_wdata = 0;
   logic [DW-1:0] rd_data, lcd_d_o, lcd_d_i;
   logic          busy, irq_wr_empty, irq_rd_full;
   logic          lcd_a0, lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_d_oe;
   logic [DW-1:0] rd_model = 8'h00;

   int n_chk = 0, n_bad = 0;
   xfer_t exp_q[$];

   always #4 clk = ~clk;

   assign lcd_d_i = lcd_rd_n ? 8'h00 : rd_model;

   lcd_par_ctrl #(.DATA_W(DW), .CNT_W(CW)) i_lcd_par_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
      .cpu_req(cpu_req), .dma_req(dma_req), .req_rd(req_rd), .req_a0(req_a0),
      .req_wdata(req_wdata), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
      .irq_wr_empty(irq_wr_empty), .irq_rd_full(irq_rd_full),
      .lcd_a0(lcd_a0), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
      .lcd_d_o(lcd_d_o), .lcd_d_oe(lcd_d_oe), .lcd_d_i(lcd_d_i)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: rebuilds each transfer from the pins and compares it
   bit act_on = 0, wr_seen, rd_seen, oe_all, oe_any, both_low;
   bit a0_s;
   bit [7:0] d0;
   int ns, nw, nh, n_xfer = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R10", "irq_wr_empty vs busy", irq_wr_empty, !busy);
         chk("R9", "busy vs chip select", busy, !lcd_cs_n);
         if (!lcd_cs_n) begin
            if (!act_on) begin
               act_on = 1; ns = 0; nw = 0; nh = 0; a0_s = lcd_a0;
               wr_seen = 0; rd_seen = 0; oe_all = 1; oe_any = 0;
               both_low = 0; d0 = lcd_d_o;
            end
            if (!lcd_wr_n && !lcd_rd_n) both_low = 1;
            if (lcd_wr_n && lcd_rd_n) begin
               if (nw == 0) ns++; else nh++;
            end else begin
               nw++;
               if (!lcd_wr_n) wr_seen = 1;
               if (!lcd_rd_n) rd_seen = 1;
            end
            if (lcd_a0 != a0_s) chk("R5", "a0 stable under cs", lcd_a0, a0_s);
            oe_all &= lcd_d_oe;
            oe_any |= lcd_d_oe;
            if (lcd_d_oe && lcd_d_o != d0) chk("R6", "write data steady", lcd_d_o, d0);
         end else if (act_on) begin
            act_on = 0;
            n_xfer++;
            chk("R6", "oe released after cs", lcd_d_oe, 0);
            if (exp_q.size() == 0) begin
               chk("R9", "unexpected transfer", 1, 0);
            end else begin
               xfer_t e;
               e = exp_q.pop_front();
               chk("R3", "setup cycles", ns, e.s + 1);
               chk("R4", "strobe cycles", nw, e.w + 1);
               chk("R4", "both strobes low", both_low, 0);
               chk("R4", "write strobe used", wr_seen, !e.rd);
               chk("R4", "read strobe used", rd_seen, e.rd);
               chk("R5", "hold cycles", nh, e.h + 1);
               chk("R2", "a0 value", a0_s, e.a0);
               if (!e.rd) begin
                  chk("R6", "oe whole write", oe_all, 1);
                  chk("R6", "write byte", d0, e.d);
               end else begin
                  chk("R6", "oe during read", oe_any, 0);
               end
            end
         end
      end
   end

   // driver: pushes the expected transfer and raises a request
   task automatic access(bit rd, bit a0, bit [7:0] d, int s, int w, int h,
                         bit use_dma, bit poke_busy);
      xfer_t e;
      @(negedge clk);
      cfg_setup = s[CW-1:0]; cfg_wait = w[CW-1:0]; cfg_hold = h[CW-1:0];
      req_rd = rd; req_a0 = a0; req_wdata = d;
      e.rd = rd; e.a0 = a0; e.d = d; e.s = s; e.w = w; e.h = h;
      exp_q.push_back(e);
      if (use_dma) dma_req = 1; else cpu_req = 1;
      @(negedge clk);
      dma_req = 0; cpu_req = 0;
      chk("R2", "cs low after accept", lcd_cs_n, 0);
      chk("R2", "busy after accept", busy, 1);
      if (poke_busy) begin
         @(negedge clk);
         req_a0 = !a0; req_rd = !rd; req_wdata = ~d;
         cpu_req = 1; dma_req = 1;
         chk("R9", "busy while poked", busy, 1);
         @(negedge clk);
         cpu_req = 0; dma_req = 0;
         chk("R9", "a0 kept after ignored req", lcd_a0, a0);
      end
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "cs_n", lcd_cs_n, 1);
      chk("R1", "wr_n", lcd_wr_n, 1);
      chk("R1", "rd_n", lcd_rd_n, 1);
      chk("R1", "oe", lcd_d_oe, 0);
      chk("R1", "busy", busy, 0);
      chk("R1", "irq_wr_empty", irq_wr_empty, 1);
      chk("R1", "irq_rd_full", irq_rd_full, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      access(0, 1, 8'hA5, 0, 0, 0, 0, 0);
      access(0, 0, 8'h3C, 2, 3, 1, 1, 0);

      rd_model = 8'h5A;
      access(1, 1, 8'h00, 1, 2, 2, 0, 0);
      chk("R7", "read byte", rd_data, 8'h5A);
      chk("R7", "read full", irq_rd_full, 1);
      rd_ack = 1;
      @(negedge clk);
      rd_ack = 0;
      chk("R8", "full cleared", irq_rd_full, 0);
      chk("R8", "data kept", rd_data, 8'h5A);

      access(0, 1, 8'h96, 3, 4, 3, 0, 1);
      chk("R9", "transfer count after poke", n_xfer, 4);

      rd_model = 8'hC3;
      access(1, 0, 8'h00, 0, 0, 0, 1, 0);
      rd_model = 8'h7E;
      access(1, 1, 8'h00, 2, 1, 0, 0, 0);
      chk("R8", "overwrite while full", rd_data, 8'h7E);
      chk("R7", "still full", irq_rd_full, 1);

      repeat (3) @(negedge clk);
      chk("R9", "queue drained", exp_q.size(), 0);
      chk("R9", "total transfers", n_xfer, 6);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule